// File: doc/BRIEF.md
# Charge Pulse Duty Modulator

The block turns a charge-phase code and a rate-mode select into a single charge-enable bit. During fast charge the enable is held high without a break. During top-off and trickle it produces a repeating pulse train. Every train has the same fixed on-time. The off-time depends on the pattern in use, which sets the average rate at 1/16 of the fast rate for top-off and at about 1/32 or 1/64 for trickle.

An inhibit input turns a fast or top-off request into the trickle train for the current mode. A power-down input forces the enable low. All durations are counted in ticks of an internal prescaler. One tick is nominally one microsecond, and a smaller prescale lets a simulation run faster.

The inputs are sampled at each clock edge and the output follows from registered state, so the enable reflects the inputs one cycle later. Whenever the selected pattern changes, the train starts again at the beginning of a full on-pulse.

Top module: `charge_pulse_mod`

## Requirements
- R1: Encodings: `phase_i` 00 = idle, 01 = fast, 10 = top-off, 11 = trickle. `mode_i` 00 = low, 01 = mid, 10 = high, and 11 is treated as high. `chg_en_o` responds to the inputs sampled at the previous rising clock edge. It is 0 while reset is asserted.
- R2: In the fast phase, with inhibit low and power-down low, `chg_en_o` stays at 1.
- R3: In the idle phase, with power-down low, `chg_en_o` stays at 0, whatever inhibit and mode are.
- R4: In the top-off phase, `chg_en_o` repeats ON_TICKS ticks high and then TOPOFF_OFF_TICKS ticks low. `mode_i` has no effect.
- R5: In the trickle phase with mid mode, `chg_en_o` repeats ON_TICKS ticks high and then TRK_MID_OFF_TICKS ticks low.
- R6: In the trickle phase with low or high mode (or code 11), `chg_en_o` repeats ON_TICKS ticks high and then TRK_LONG_OFF_TICKS ticks low.
- R7: When inhibit is high in the fast or top-off phase, `chg_en_o` follows the trickle pattern that the current mode selects (R5/R6). When inhibit is high in the trickle or idle phase, it has no effect.
- R8: When power-down is high, `chg_en_o` is 0. Power-down overrides phase and inhibit.
- R9: Any change of the selected pattern restarts the train at the first cycle of a full-length on-pulse. A mode change during top-off is not a pattern change.
- R10: One tick lasts PRESCALE clock cycles, counted from the start of a pattern. A high time of N ticks therefore lasts N*PRESCALE cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_i | input | 2 | Charge phase code (R1) |
| mode_i | input | 2 | Rate mode select (R1) |
| inhibit_i | input | 1 | Inhibit: fast/top-off fall back to trickle |
| pwrdn_i | input | 1 | Power-down: forces the enable low |
| chg_en_o | output | 1 | Charge enable |

## Verification
The reference model follows each pattern as a position counted from its last restart and compares every cycle. The stimulus covers each phase with each mode, including the reserved mode code, so that the short and long trickle off-times and the top-off off-time are told apart by where each edge falls. A mode change in the middle of top-off checks that the train is not restarted, while switches from trickle to top-off taken mid-pulse, inhibit applied and released, and power-down entered and left check that each restart begins with a full on-pulse. Inhibit during idle and trickle confirms that it has no effect in those phases.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'b00,
    PH_FAST    = 2'b01,
    PH_TOPOFF  = 2'b10,
    PH_TRICKLE = 2'b11
  } phase_e;

  typedef enum logic [1:0] {
    MD_LOW  = 2'b00,
    MD_MID  = 2'b01,
    MD_HIGH = 2'b10,
    MD_RSVD = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    PAT_OFF      = 3'd0,
    PAT_FAST     = 3'd1,
    PAT_TOPOFF   = 3'd2,
    PAT_TRK_MID  = 3'd3,
    PAT_TRK_LONG = 3'd4
  } pat_e;

  typedef enum logic {
    SEG_ON  = 1'b0,
    SEG_OFF = 1'b1
  } seg_e;

  function automatic pat_e trickle_pat(mode_e m);
    return (m == MD_MID) ? PAT_TRK_MID : PAT_TRK_LONG;
  endfunction

  function automatic logic is_pulsed(pat_e p);
    return (p == PAT_TOPOFF) || (p == PAT_TRK_MID) || (p == PAT_TRK_LONG);
  endfunction
endpackage

// File: rtl/cpm_pattern_sel.sv
module cpm_pattern_sel
  import cpm_pkg::*;
(
  input  logic [1:0] phase_i,
  input  logic [1:0] mode_i,
  input  logic       inhibit_i,
  input  logic       pwrdn_i,
  output pat_e       pat_o
);
  phase_e ph;
  mode_e  md;

  assign ph = phase_e'(phase_i);
  assign md = mode_e'(mode_i);

  always_comb begin
    pat_o = PAT_OFF;
    if (!pwrdn_i) begin
      unique case (ph)
        PH_IDLE:    pat_o = PAT_OFF;
        PH_FAST:    pat_o = inhibit_i ? trickle_pat(md) : PAT_FAST;
        PH_TOPOFF:  pat_o = inhibit_i ? trickle_pat(md) : PAT_TOPOFF;
        PH_TRICKLE: pat_o = trickle_pat(md);
        default:    pat_o = PAT_OFF;
      endcase
    end
  end
endmodule

// File: rtl/cpm_tick_div.sv
module cpm_tick_div #(
  parameter int PRESCALE = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [W-1:0] LAST = W'(PRESCALE - 1);

  generate
    if (PRESCALE <= 1) begin : g_bypass
      assign tick_o = 1'b1;
    end else begin : g_count
      logic [W-1:0] cnt_q;
      assign tick_o = (cnt_q == LAST);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                cnt_q <= '0;
        else if (clr_i || tick_o)   cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/cpm_seg_seq.sv
module cpm_seg_seq
  import cpm_pkg::*;
#(
  parameter int ON_TICKS           = 286,
  parameter int TOPOFF_OFF_TICKS   = 4290,
  parameter int TRK_MID_OFF_TICKS  = 8860,
  parameter int TRK_LONG_OFF_TICKS = 18000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic active_i,
  input  pat_e pat_i,
  input  logic tick_i,
  output seg_e seg_o
);
  localparam int MAX_A = (ON_TICKS > TOPOFF_OFF_TICKS) ? ON_TICKS : TOPOFF_OFF_TICKS;
  localparam int MAX_B = (TRK_MID_OFF_TICKS > TRK_LONG_OFF_TICKS) ? TRK_MID_OFF_TICKS
                                                                  : TRK_LONG_OFF_TICKS;
  localparam int MAXT  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int W     = (MAXT > 1) ? $clog2(MAXT) : 1;

  localparam logic [W-1:0] ON_LAST   = W'(ON_TICKS - 1);
  localparam logic [W-1:0] TOP_LAST  = W'(TOPOFF_OFF_TICKS - 1);
  localparam logic [W-1:0] MID_LAST  = W'(TRK_MID_OFF_TICKS - 1);
  localparam logic [W-1:0] LONG_LAST = W'(TRK_LONG_OFF_TICKS - 1);

  seg_e         seg_q;
  logic [W-1:0] tcnt_q;
  logic [W-1:0] off_last;
  logic [W-1:0] seg_last;

  always_comb begin
    unique case (pat_i)
      PAT_TOPOFF:  off_last = TOP_LAST;
      PAT_TRK_MID: off_last = MID_LAST;
      default:     off_last = LONG_LAST;
    endcase
  end

  assign seg_last = (seg_q == SEG_ON) ? ON_LAST : off_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q  <= SEG_ON;
      tcnt_q <= '0;
    end else if (restart_i || !active_i) begin
      seg_q  <= SEG_ON;
      tcnt_q <= '0;
    end else if (tick_i) begin
      if (tcnt_q == seg_last) begin
        seg_q  <= (seg_q == SEG_ON) ? SEG_OFF : SEG_ON;
        tcnt_q <= '0;
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end

  assign seg_o = seg_q;
endmodule

// File: rtl/charge_pulse_mod.sv
module charge_pulse_mod
  import cpm_pkg::*;
#(
  parameter int PRESCALE           = 8,
  parameter int ON_TICKS           = 286,
  parameter int TOPOFF_OFF_TICKS   = 4290,
  parameter int TRK_MID_OFF_TICKS  = 8860,
  parameter int TRK_LONG_OFF_TICKS = 18000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] phase_i,
  input  logic [1:0] mode_i,
  input  logic       inhibit_i,
  input  logic       pwrdn_i,
  output logic       chg_en_o
);
  pat_e pat_d, pat_q;
  seg_e seg;
  logic restart, active, tick;

  cpm_pattern_sel u_sel (
    .phase_i   (phase_i),
    .mode_i    (mode_i),
    .inhibit_i (inhibit_i),
    .pwrdn_i   (pwrdn_i),
    .pat_o     (pat_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pat_q <= PAT_OFF;
    else         pat_q <= pat_d;
  end

  assign restart = (pat_d != pat_q);
  assign active  = is_pulsed(pat_q);

  cpm_tick_div #(.PRESCALE(PRESCALE)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (restart || !active),
    .tick_o (tick)
  );

  cpm_seg_seq #(
    .ON_TICKS           (ON_TICKS),
    .TOPOFF_OFF_TICKS   (TOPOFF_OFF_TICKS),
    .TRK_MID_OFF_TICKS  (TRK_MID_OFF_TICKS),
    .TRK_LONG_OFF_TICKS (TRK_LONG_OFF_TICKS)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .active_i  (active),
    .pat_i     (pat_q),
    .tick_i    (tick),
    .seg_o     (seg)
  );

  assign chg_en_o = (pat_q == PAT_FAST) || (active && (seg == SEG_ON));
endmodule

// File: rtl/cpm_checker.sv
module cpm_checker #(
  parameter int PRESCALE = 8
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] phase_i,
  input logic [1:0] mode_i,
  input logic       inhibit_i,
  input logic       pwrdn_i,
  input logic       chg_en_o,
  input logic       tick_i
);
  assert_pwrdn_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwrdn_i |=> !chg_en_o);

  assert_rise_needs_power_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chg_en_o) |-> !$past(pwrdn_i));

  assert_fast_on_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == 2'b01 && !inhibit_i && !pwrdn_i) |=> chg_en_o);

  assert_idle_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == 2'b00) |=> !chg_en_o);

  assert_tick_spacing_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (PRESCALE > 1 && tick_i) |=> !tick_i);

  logic unused_mode;
  assign unused_mode = ^mode_i;
endmodule

bind charge_pulse_mod cpm_checker #(.PRESCALE(PRESCALE)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .phase_i   (phase_i),
  .mode_i    (mode_i),
  .inhibit_i (inhibit_i),
  .pwrdn_i   (pwrdn_i),
  .chg_en_o  (chg_en_o),
  .tick_i    (tick)
);

// File: tb/charge_pulse_mod_tb_top.sv
module charge_pulse_mod_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PS   = 2;
  localparam int ON   = 3;
  localparam int TOP  = 7;
  localparam int MID  = 11;
  localparam int LONG = 17;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] phase = 2'b00;
  logic [1:0] mode = 2'b00;
  logic       inh = 1'b0;
  logic       pd = 1'b0;
  logic       en;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // model state
  int    msel = 0;   // 0 off, 1 fast, 2 top-off, 3 trickle mid, 4 trickle long
  int    pos  = 0;
  string mtag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  charge_pulse_mod #(
    .PRESCALE           (PS),
    .ON_TICKS           (ON),
    .TOPOFF_OFF_TICKS   (TOP),
    .TRK_MID_OFF_TICKS  (MID),
    .TRK_LONG_OFF_TICKS (LONG)
  ) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .phase_i   (phase),
    .mode_i    (mode),
    .inhibit_i (inh),
    .pwrdn_i   (pd),
    .chg_en_o  (en)
  );

  function automatic int trk_sel(logic [1:0] m);
    return (m == 2'b01) ? 3 : 4;
  endfunction

  function automatic int sel_of(logic [1:0] p, logic [1:0] m, logic i, logic d);
    if (d) return 0;
    case (p)
      2'b00:   return 0;
      2'b01:   return i ? trk_sel(m) : 1;
      2'b10:   return i ? trk_sel(m) : 2;
      default: return trk_sel(m);
    endcase
  endfunction

  function automatic string tag_of(logic [1:0] p, logic [1:0] m, logic i, logic d);
    if (d) return "R8";
    if (p == 2'b00) return "R3";
    if (i && p != 2'b11) return "R7";
    if (p == 2'b01) return "R2";
    if (p == 2'b10) return "R4";
    return (m == 2'b01) ? "R5" : "R6";
  endfunction

  function automatic logic expect_en();
    int off, per;
    if (msel == 0) return 1'b0;
    if (msel == 1) return 1'b1;
    off = (msel == 2) ? TOP : (msel == 3) ? MID : LONG;
    per = (ON + off) * PS;
    // R10: high time is ON*PS cycles
    return ((pos % per) < ON * PS);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msel = 0;
      pos  = 0;
    end else begin
      int ns;
      ns = sel_of(phase, mode, inh, pd);
      mtag = tag_of(phase, mode, inh, pd);
      if (ns != msel) begin
        msel = ns;
        pos  = 0;
      end else begin
        pos = pos + 1;
      end
      if (msel >= 2 && pos < ON * PS) mtag = {mtag, "/R9"};
    end
  end

  task automatic check(logic exp, string tag);
    n_cmp++;
    if (en !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t chg_en_o=%b expected=%b", tag, $time, en, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) check(expect_en(), mtag);
  end

  task automatic run(logic [1:0] p, logic [1:0] m, logic i, logic d, int n);
    phase = p; mode = m; inh = i; pd = d;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    check(1'b0, "R1");          // reset state
    rst_n = 1'b1;
    run(2'b00, 2'b00, 1'b0, 1'b0, 10);  // R3 idle
    run(2'b00, 2'b01, 1'b1, 1'b0, 8);   // R3 idle, inhibit ignored
    run(2'b01, 2'b00, 1'b0, 1'b0, 20);  // R2 fast
    run(2'b10, 2'b00, 1'b0, 1'b0, 47);  // R4 top-off
    run(2'b10, 2'b10, 1'b0, 1'b0, 33);  // R9 mode change in top-off: no restart
    run(2'b11, 2'b01, 1'b0, 1'b0, 70);  // R5 trickle mid
    run(2'b11, 2'b00, 1'b0, 1'b0, 90);  // R6 trickle low
    run(2'b11, 2'b10, 1'b0, 1'b0, 45);  // R6 high: same pattern as low
    run(2'b11, 2'b11, 1'b0, 1'b0, 45);  // R1 code 11 as high
    run(2'b11, 2'b01, 1'b1, 1'b0, 35);  // R7 inhibit in trickle: no effect beyond mode
    run(2'b11, 2'b01, 1'b0, 1'b0, 5);   // mid-pulse
    run(2'b10, 2'b01, 1'b0, 1'b0, 30);  // R9 restart into top-off
    run(2'b01, 2'b01, 1'b1, 1'b0, 70);  // R7 fast+inhibit -> trickle mid
    run(2'b10, 2'b10, 1'b1, 1'b0, 90);  // R7 top-off+inhibit -> trickle long
    run(2'b10, 2'b10, 1'b0, 1'b0, 25);  // R9 inhibit released
    run(2'b01, 2'b00, 1'b0, 1'b0, 10);  // R2
    run(2'b10, 2'b00, 1'b0, 1'b0, 4);
    run(2'b10, 2'b00, 1'b0, 1'b1, 20);  // R8 power-down in top-off
    run(2'b10, 2'b00, 1'b0, 1'b0, 30);  // R9 restart after power-down
    run(2'b01, 2'b00, 1'b1, 1'b1, 10);  // R8 overrides fast and inhibit
    run(2'b01, 2'b00, 1'b0, 1'b0, 10);  // R2
    run(2'b00, 2'b00, 1'b0, 1'b0, 10);  // R3
    finish_run();
  end
endmodule